// File: doc/BRIEF.md
# Receive Clock Phase Stepper

This block moves the sampling phase of a delay-locked loop's receive clock to a new value without glitching the clock. A controller sends a 4-bit phase number in the range 0 to 15 together with a one-cycle start pulse. The block then runs a fixed sequence on the DLL control lines:

1. It takes the recovered-clock loop out of control, puts the DLL under external phase selection and gates the clock output off.
2. It waits until the DLL reports that the output is gated.
3. It writes the Gray-coded phase.
4. It turns the output back on and waits until the DLL reports that the output is running.
5. It returns control to the clock-data-recovery loop.

Each of the two waits polls the DLL status once per microsecond tick, up to a fixed number of polls. If the status never arrives, the block aborts with a timeout. A single-cycle done pulse or a single-cycle error pulse reports the result. The microsecond tick comes from an internal divider of the system clock.

Top module: `dll_phase_seq`

## Requirements
- R1: After reset every control output (cdr_en_o, ext_sel_o, dll_en_o, ck_out_en_o, phase_sel_o) is 0, and busy_o, done_o and err_o are 0.
- R2: A start_i pulse accepted while idle gives, on the next cycle, busy_o=1, cdr_en_o=0, ck_out_en_o=0, ext_sel_o=1 and dll_en_o=1.
- R3: start_i while busy_o=1 is ignored. The phase captured at acceptance is the one that is finally applied, and no extra sequence or done pulse follows.
- R4: phase_sel_o changes only after ck_out_stat_i has been polled as 0, and only while ck_out_en_o=0 and cdr_en_o=0. The value written is the Gray code of the request, g[i]=b[i]^b[i+1] with the top bit passed through (0,1,3,2,6,7,5,4,12,13,15,14,10,11,9,8 for requests 0..15).
- R5: ck_out_en_o rises on the cycle after the phase write, with ext_sel_o=1 and cdr_en_o=0. The block then waits for ck_out_stat_i=1.
- R6: On success, cdr_en_o=1, ext_sel_o=0, ck_out_en_o=1 and dll_en_o=1 are set, a one-cycle done_o is raised, and busy_o falls in the same cycle.
- R7: In each wait, ck_out_stat_i is polled only on tick cycles, with at most POLLS polls. If the POLLS-th poll still mismatches, err_o pulses for one cycle, err_stage_o tells which wait failed (0 = waiting for gated, 1 = waiting for running), and the block returns to idle.
- R8: Ticks are exactly TICK_DIV clock cycles apart. A wait that always mismatches therefore ends between (POLLS-1)*TICK_DIV+1 and POLLS*TICK_DIV cycles after it begins.
- R9: done_o and err_o each last one cycle and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to apply a new phase |
| phase_i | input | 4 | Requested phase number, binary 0..15 |
| ck_out_stat_i | input | 1 | DLL status: clock output currently running |
| cdr_en_o | output | 1 | Clock-data-recovery loop enable |
| ext_sel_o | output | 1 | External phase-select enable |
| dll_en_o | output | 1 | DLL enable |
| ck_out_en_o | output | 1 | Clock output enable |
| phase_sel_o | output | 4 | Gray-coded phase select field |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | One-cycle pulse: phase applied |
| err_o | output | 1 | One-cycle pulse: status wait timed out |
| err_stage_o | output | 1 | With err_o: 0 gate-off wait, 1 enable wait |

## Verification
The assertions check the following on every cycle:
- the control pattern that follows an accepted start;
- that the phase field moves only while the output is gated and the recovery loop is off;
- the state of the enables when the output rises;
- the final hand-back pattern with done;
- the single-cycle, exclusive nature of done and error;
- a bound on the number of ticks spent in a sequence.

Only the directed scenarios can show the other behaviours. These are:
- the Gray mapping for all sixteen requests;
- that a start arriving mid-sequence is dropped;
- that a slow status response inside the poll budget still passes, while one beyond it times out in the right stage;
- the absolute timeout window in cycles.

// File: rtl/dps_pkg.sv
package dps_pkg;

    localparam int unsigned DPS_PHASE_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_LO = 2'd1,
        ST_ARM     = 2'd2,
        ST_WAIT_HI = 2'd3
    } dps_state_e;

    typedef struct packed {
        dps_state_e             st;
        logic [DPS_PHASE_W-1:0] req;
        logic                   cdr;
        logic                   ext;
        logic                   dll;
        logic                   ck;
        logic [DPS_PHASE_W-1:0] sel;
        logic                   done;
        logic                   err;
        logic                   err_stage;
    } dps_regs_t;

    localparam dps_regs_t DPS_RESET = '{
        st:        ST_IDLE,
        req:       '0,
        cdr:       1'b0,
        ext:       1'b0,
        dll:       1'b0,
        ck:        1'b0,
        sel:       '0,
        done:      1'b0,
        err:       1'b0,
        err_stage: 1'b0
    };

endpackage

// File: rtl/dps_tick_gen.sv
module dps_tick_gen #(
    parameter int unsigned TICK_DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/dps_poll_ctr.sv
module dps_poll_ctr #(
    parameter int unsigned POLLS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic miss_i,
    output logic last_o
);
    localparam int unsigned CW = $clog2(POLLS + 1);
    localparam logic [CW-1:0] LAST = CW'(POLLS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)       cnt_d = '0;
        else if (miss_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/dps_gray_map.sv
module dps_gray_map #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] bin_i,
    output logic [W-1:0] gray_o
);
    assign gray_o[W-1] = bin_i[W-1];
    for (genvar i = 0; i < W - 1; i++) begin : g_bit
        assign gray_o[i] = bin_i[i] ^ bin_i[i+1];
    end
endmodule

// File: rtl/dll_phase_seq.sv
module dll_phase_seq
    import dps_pkg::*;
#(
    parameter int unsigned TICK_DIV = 100,
    parameter int unsigned POLLS    = 50
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [DPS_PHASE_W-1:0] phase_i,
    input  logic                   ck_out_stat_i,
    output logic                   cdr_en_o,
    output logic                   ext_sel_o,
    output logic                   dll_en_o,
    output logic                   ck_out_en_o,
    output logic [DPS_PHASE_W-1:0] phase_sel_o,
    output logic                   busy_o,
    output logic                   done_o,
    output logic                   err_o,
    output logic                   err_stage_o
);
    dps_regs_t              r_d, r_q;
    logic                   tick_w;
    logic                   poll_last_w;
    logic                   poll_clr_w;
    logic                   poll_miss_w;
    logic [DPS_PHASE_W-1:0] gray_w;

    dps_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_w)
    );

    dps_poll_ctr #(.POLLS(POLLS)) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (poll_clr_w),
        .miss_i (poll_miss_w),
        .last_o (poll_last_w)
    );

    dps_gray_map #(.W(DPS_PHASE_W)) u_gray (
        .bin_i  (r_q.req),
        .gray_o (gray_w)
    );

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.err     = 1'b0;
        poll_clr_w  = 1'b0;
        poll_miss_w = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                poll_clr_w = 1'b1;
                if (start_i) begin
                    r_d.req = phase_i;
                    r_d.cdr = 1'b0;
                    r_d.ck  = 1'b0;
                    r_d.ext = 1'b1;
                    r_d.dll = 1'b1;
                    r_d.st  = ST_WAIT_LO;
                end
            end
            ST_WAIT_LO: begin
                if (tick_w) begin
                    if (!ck_out_stat_i) begin
                        r_d.sel    = gray_w;
                        r_d.st     = ST_ARM;
                        poll_clr_w = 1'b1;
                    end else if (poll_last_w) begin
                        r_d.err       = 1'b1;
                        r_d.err_stage = 1'b0;
                        r_d.st        = ST_IDLE;
                        poll_clr_w    = 1'b1;
                    end else begin
                        poll_miss_w = 1'b1;
                    end
                end
            end
            ST_ARM: begin
                r_d.ck     = 1'b1;
                r_d.st     = ST_WAIT_HI;
                poll_clr_w = 1'b1;
            end
            ST_WAIT_HI: begin
                if (tick_w) begin
                    if (ck_out_stat_i) begin
                        r_d.cdr    = 1'b1;
                        r_d.ext    = 1'b0;
                        r_d.done   = 1'b1;
                        r_d.st     = ST_IDLE;
                        poll_clr_w = 1'b1;
                    end else if (poll_last_w) begin
                        r_d.err       = 1'b1;
                        r_d.err_stage = 1'b1;
                        r_d.st        = ST_IDLE;
                        poll_clr_w    = 1'b1;
                    end else begin
                        poll_miss_w = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= DPS_RESET;
        else        r_q <= r_d;
    end

    assign cdr_en_o    = r_q.cdr;
    assign ext_sel_o   = r_q.ext;
    assign dll_en_o    = r_q.dll;
    assign ck_out_en_o = r_q.ck;
    assign phase_sel_o = r_q.sel;
    assign busy_o      = (r_q.st != ST_IDLE);
    assign done_o      = r_q.done;
    assign err_o       = r_q.err;
    assign err_stage_o = r_q.err_stage;
endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
    parameter int unsigned POLLS = 50
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o,
    input logic       cdr_en_o,
    input logic       ext_sel_o,
    input logic       dll_en_o,
    input logic       ck_out_en_o,
    input logic [3:0] phase_sel_o,
    input logic       tick_w
);
    localparam int unsigned TW = $clog2(POLLS + 4);
    localparam logic [TW-1:0] TMAX = TW'(POLLS + 1);

    logic [TW-1:0] ticks_q;
    logic          ck_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ticks_q   <= '0;
            ck_prev_q <= 1'b0;
        end else begin
            ck_prev_q <= ck_out_en_o;
            if ((start_i && !busy_o) || (ck_out_en_o && !ck_prev_q))
                ticks_q <= '0;
            else if (busy_o && tick_w && ticks_q != '1)
                ticks_q <= ticks_q + 1'b1;
        end
    end

    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && ext_sel_o && dll_en_o && !cdr_en_o && !ck_out_en_o));

    a_r4_phase_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_sel_o) |-> (!ck_out_en_o && !cdr_en_o && ext_sel_o));

    a_r5_enable_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ck_out_en_o) |-> (ext_sel_o && !cdr_en_o && dll_en_o));

    a_r6_handback: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cdr_en_o && !ext_sel_o && ck_out_en_o && dll_en_o && !busy_o));

    a_r7_tick_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (ticks_q <= TMAX));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));
endmodule

bind dll_phase_seq dps_checker #(.POLLS(POLLS)) u_dps_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .cdr_en_o    (cdr_en_o),
    .ext_sel_o   (ext_sel_o),
    .dll_en_o    (dll_en_o),
    .ck_out_en_o (ck_out_en_o),
    .phase_sel_o (phase_sel_o),
    .tick_w      (tick_w)
);

// File: tb/tb_dll_phase_seq.sv
module tb_dll_phase_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int NPOLL      = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [3:0] phase_i = '0;
    logic       stat = 1'b0;
    logic       cdr_en_o, ext_sel_o, dll_en_o, ck_out_en_o;
    logic [3:0] phase_sel_o;
    logic       busy_o, done_o, err_o, err_stage_o;

    int total = 0;
    int fails = 0;
    int lag = 0;
    int lag_cnt = 0;
    logic stuck_en = 1'b0;
    logic stuck_val = 1'b0;
    int order_bad = 0;
    logic [3:0] sel_prev = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dll_phase_seq #(.TICK_DIV(DIV), .POLLS(NPOLL)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .phase_i(phase_i),
        .ck_out_stat_i(stat), .cdr_en_o(cdr_en_o), .ext_sel_o(ext_sel_o),
        .dll_en_o(dll_en_o), .ck_out_en_o(ck_out_en_o), .phase_sel_o(phase_sel_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_stage_o(err_stage_o)
    );

    // DLL status model: follows the clock enable after lag cycles, or is stuck
    always @(posedge clk) begin
        if (!rst_n) begin
            stat <= 1'b0; lag_cnt <= 0;
        end else if (stuck_en) begin
            stat <= stuck_val; lag_cnt <= 0;
        end else if (stat != ck_out_en_o) begin
            if (lag_cnt >= lag) begin stat <= ck_out_en_o; lag_cnt <= 0; end
            else lag_cnt <= lag_cnt + 1;
        end else lag_cnt <= 0;
    end

    // R4 ordering monitor: phase field moves only while gated and status low
    always @(negedge clk) begin
        if (rst_n && phase_sel_o != sel_prev) begin
            if (ck_out_en_o || cdr_en_o || stat) order_bad++;
        end
        sel_prev = phase_sel_o;
    end

    function automatic logic [3:0] gray(input logic [3:0] b);
        return b ^ (b >> 1);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [3:0] ph);
        @(negedge clk);
        phase_i = ph; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // runs one sequence; returns cycles until done/err and which one fired
    task automatic run_seq(input logic [3:0] ph, input logic extra_start,
                           output int n, output logic got_done, output logic got_err);
        logic seen_rise = 1'b0;
        logic rise_ok = 1'b0;
        @(negedge clk);
        phase_i = ph; start_i = 1'b1;
        n = 0; got_done = 0; got_err = 0;
        while (!got_done && !got_err && n < 1000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            start_i = 1'b0;
            if (n == 1) begin
                check("R2 step one", {busy_o, ext_sel_o, dll_en_o, cdr_en_o, ck_out_en_o}, 5'b11100);
                if (extra_start) begin phase_i = ph ^ 4'hA; start_i = 1'b1; end
            end
            if (ck_out_en_o && !seen_rise) begin
                seen_rise = 1'b1;
                rise_ok = ext_sel_o && !cdr_en_o && (phase_sel_o == gray(ph));
            end
            got_done = done_o; got_err = err_o;
        end
        if (got_done) check("R5 enable after phase write", {31'd0, rise_ok}, 32'd1);
    endtask

    task automatic t_reset;
        check("R1 reset controls", {cdr_en_o, ext_sel_o, dll_en_o, ck_out_en_o, phase_sel_o}, 8'h00);
        check("R1 reset flags", {busy_o, done_o, err_o}, 3'b000);
    endtask

    task automatic t_all_phases(input int lg);
        int n; logic d, e;
        lag = lg;
        for (int p = 0; p < 16; p++) begin
            run_seq(4'(p), 1'b0, n, d, e);
            check("R6 done", {d, e}, 2'b10);
            check("R4 gray phase", {28'd0, phase_sel_o}, {28'd0, gray(4'(p))});
            check("R6 handback", {cdr_en_o, ext_sel_o, ck_out_en_o, dll_en_o, busy_o}, 5'b10110);
            @(negedge clk);
            check("R9 done one cycle", {31'd0, done_o}, 32'd0);
        end
    endtask

    task automatic t_ignore_busy;
        int n; logic d, e;
        lag = 2;
        run_seq(4'd5, 1'b1, n, d, e);
        check("R3 first request completes", {d, e}, 2'b10);
        check("R3 captured phase kept", {28'd0, phase_sel_o}, {28'd0, gray(4'd5)});
        for (int i = 0; i < 3 * DIV * 4; i++) begin
            @(negedge clk);
            if (busy_o || done_o) begin
                check("R3 no second sequence", {busy_o, done_o}, 2'b00);
                break;
            end
        end
        check("R3 idle after", {31'd0, busy_o}, 32'd0);
    endtask

    task automatic t_slow_pass;
        int n; logic d, e;
        lag = (NPOLL - 12) * DIV;
        run_seq(4'd11, 1'b0, n, d, e);
        check("R7 slow status within budget passes", {d, e}, 2'b10);
        check("R4 gray phase slow", {28'd0, phase_sel_o}, {28'd0, gray(4'd11)});
    endtask

    task automatic t_timeout_lo;
        int n; logic d, e;
        stuck_en = 1'b1; stuck_val = 1'b1;
        run_seq(4'd3, 1'b0, n, d, e);
        check("R7 gate-off wait times out", {d, e}, 2'b01);
        check("R7 stage 0", {31'd0, err_stage_o}, 32'd0);
        check("R8 timeout window low", {31'd0, n >= (NPOLL - 1) * DIV + 2}, 32'd1);
        check("R8 timeout window high", {31'd0, n <= NPOLL * DIV + 1}, 32'd1);
        check("R7 idle after error", {31'd0, busy_o}, 32'd0);
        @(negedge clk);
        check("R9 err one cycle", {31'd0, err_o}, 32'd0);
        stuck_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_timeout_hi;
        int n; logic d, e;
        stuck_en = 1'b1; stuck_val = 1'b0;
        run_seq(4'd9, 1'b0, n, d, e);
        check("R7 enable wait times out", {d, e}, 2'b01);
        check("R7 stage 1", {31'd0, err_stage_o}, 32'd1);
        check("R4 phase written before stall", {28'd0, phase_sel_o}, {28'd0, gray(4'd9)});
        check("R7 idle after stage1 error", {31'd0, busy_o}, 32'd0);
        stuck_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_late_timeout;
        int n; logic d, e;
        lag = (NPOLL + 5) * DIV;
        run_seq(4'd6, 1'b0, n, d, e);
        check("R7 late status times out", {d, e}, 2'b01);
        lag = 0;
        repeat (lag + (NPOLL + 8) * DIV) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_all_phases(0);
        t_all_phases(3 * DIV);
        t_ignore_busy();
        t_slow_pass();
        t_timeout_lo();
        t_timeout_hi();
        t_late_timeout();
        check("R4 phase moved only while gated", order_bad, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule